// File: doc/BRIEF.md
# SPI Master Channel Engine

This block is one SPI master channel. Software-side logic writes a word into a transmit holding register, and the engine shifts it out on MOSI. At the same time it samples MISO into a receive holding register. Three status flags report the channel state: TXS means the transmit holder is free, RXS means a received word is waiting, and EOT means the shifter is idle with nothing queued. The engine drives SCLK and a chip-select whose polarity is programmable.

All settings come from configuration inputs:

- word length, stored as length minus one;
- a power-of-two clock divider;
- clock polarity and clock phase;
- chip-select polarity;
- a forced chip-select;
- a two-bit transfer mode: full duplex, receive-only or transmit-only.

In receive-only mode one dummy transmit write starts the first word. After that, each read of the receive holder starts the next word. Switching to full duplex before the last read stops the stream. A forced chip-select stays asserted across words and does not depend on the channel enable.

Top module: `spi_chan_engine`

## Requirements
- R1: A word is `wlen_m1_i`+1 bits long (4 to 32). The transmit word is taken right-aligned and sent most significant bit first. The received word is stored right-aligned, with all bits above the word length at zero.
- R2: While shifting, every SCLK half-period lasts 2^`clk_div_i` cycles of `clk_i`, so the first-to-last SCLK edge of an N-bit word spans (2N-1)·2^D cycles. When idle, SCLK rests at `cpol_i`.
- R3: With `cpha_i`=0 the engine samples MISO on the leading SCLK edge and changes MOSI on the trailing edge. With `cpha_i`=1 it changes MOSI on the leading edge and samples on the trailing edge. This holds for both values of `cpol_i`.
- R4: With `cs_low_i`=1 the chip-select is active-low. With `cs_low_i`=0 it is active-high.
- R5: When `force_cs_i`=1, chip-select is active regardless of `en_i`. When `force_cs_i`=0, chip-select is active only while a word is shifting.
- R6: The mode encoding is 2'b00 full duplex, 2'b01 receive-only and 2'b10 transmit-only; 2'b11 behaves as full duplex. In transmit-only mode a finished word leaves RXS and `rx_data_o` unchanged.
- R7: In receive-only mode nothing shifts until the transmit holder is written; that write starts the first word. A receive read made while the mode is 2'b01 and the channel is enabled starts one more word. A read made after the mode has returned to 2'b00 starts nothing.
- R8: TXS is 1 when the transmit holder is empty. An enabled write clears TXS on the next cycle. TXS returns to 1 when the word moves into the shifter, which lets the next word be written while the current one shifts.
- R9: RXS rises when a word completes in full-duplex or receive-only mode. A receive read clears it on the next cycle.
- R10: EOT is 1 only when the shifter is idle and no word is pending.
- R11: While `en_i`=0, transmit writes are discarded and no new word starts. A word already shifting runs to completion. Once idle, TXS=1 and RXS=0.
- R12: After reset, TXS=1, RXS=0, EOT=1, `rx_data_o`=0, chip-select is inactive and SCLK equals `cpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Transfer mode (00 duplex, 01 receive-only, 10 transmit-only) |
| wlen_m1_i | input | 5 | Word length minus one |
| clk_div_i | input | 4 | Divider exponent D |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cs_low_i | input | 1 | 1: chip-select active-low |
| force_cs_i | input | 1 | Hold chip-select active |
| tx_wr_i | input | 1 | Write strobe for the transmit holder |
| tx_data_i | input | 32 | Transmit word, right-aligned |
| rx_rd_i | input | 1 | Read strobe for the receive holder |
| rx_data_o | output | 32 | Receive holder contents |
| txs_o | output | 1 | Transmit holder empty |
| rxs_o | output | 1 | Receive word waiting |
| eot_o | output | 1 | Shifter idle, nothing pending |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 1 | Chip-select |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume three things about the inputs:

- Word length, divider, polarity and phase stay constant while a word is shifting.
- The word length is at least four bits.
- Read and write strobes are single-cycle pulses.

The stimulus changes configuration only after EOT has been seen. It first parks a bus-side slave model, and releases it after the new settings have settled. That way, the SCLK movement caused by a polarity change is never counted as a bit. The sweep covers every polarity and phase combination, four word lengths and three divider values.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  typedef enum logic [1:0] {
    XFER_DUPLEX  = 2'b00,
    XFER_RX_ONLY = 2'b01,
    XFER_TX_ONLY = 2'b10,
    XFER_RSVD    = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // 1 << 2^DIV_W-1 wraps to zero, so the all-ones limit is still 2^D - 1
  assign limit  = (CNT_W'(1) << div_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [LEN_W-1:0]  wlen_m1_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int unsigned      EDGE_W  = LEN_W + 1;
  localparam logic [LEN_W-1:0] MSB_POS = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [EDGE_W-1:0] eidx_q, last_eidx;
  logic              busy_q, sclk_q;
  logic              leading, sample_now, shift_now, at_last;
  logic [LEN_W-1:0]  align_sh;

  // even edge index = leading edge, odd = trailing
  assign last_eidx  = {wlen_m1_i, 1'b1};
  assign leading    = ~eidx_q[0];
  assign sample_now = cpha_i ? ~leading : leading;
  assign shift_now  = cpha_i ? (leading && (eidx_q != '0)) : ~leading;
  assign at_last    = (eidx_q == last_eidx);
  assign align_sh   = MSB_POS - wlen_m1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      eidx_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      sclk_q  <= cpol_i;
      eidx_q  <= '0;
      tx_sr_q <= word_i << align_sh;
      rx_sr_q <= '0;
    end else if (busy_q && tick_i) begin
      sclk_q <= ~sclk_q;
      if (sample_now) rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_i};
      if (shift_now)  tx_sr_q <= tx_sr_q << 1;
      if (at_last) busy_q <= 1'b0;
      else         eidx_q <= eidx_q + EDGE_W'(1);
    end else if (!busy_q) begin
      sclk_q <= cpol_i;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q & tick_i & at_last;
  // phase 1 takes its final sample on the completing edge itself
  assign rx_word_o = cpha_i ? {rx_sr_q[DATA_W-2:0], miso_i} : rx_sr_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sr_q[DATA_W-1];

  // R2
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(sclk_o));
  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !load_i |=> sclk_o == $past(cpol_i));
endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
  import spi_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic              force_cs_i,
  input  logic              cs_low_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              sh_busy_i,
  input  logic              sh_done_i,
  input  logic [DATA_W-1:0] sh_word_i,
  output logic              load_o,
  output logic [DATA_W-1:0] load_word_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              txs_o,
  output logic              rxs_o,
  output logic              eot_o,
  output logic              cs_o
);
  xfer_mode_e        mode;
  logic              tx_full_q, rx_full_q, rx_trig_q;
  logic [DATA_W-1:0] tx_hold_q, rx_hold_q;
  logic              pending, capture, cs_act;

  assign mode    = xfer_mode_e'(mode_i);
  assign pending = tx_full_q | rx_trig_q;
  assign load_o  = en_i & ~sh_busy_i & pending;
  assign capture = sh_done_i & en_i & (mode != XFER_TX_ONLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      rx_trig_q <= 1'b0;
      tx_hold_q <= '0;
      rx_hold_q <= '0;
    end else if (!en_i && !sh_busy_i) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      rx_trig_q <= 1'b0;
    end else begin
      if (load_o) begin
        tx_full_q <= 1'b0;
        rx_trig_q <= 1'b0;
      end
      if (tx_wr_i && en_i) begin
        tx_hold_q <= tx_data_i;
        tx_full_q <= 1'b1;
      end
      if (rx_rd_i) begin
        rx_full_q <= 1'b0;
        if (en_i && mode == XFER_RX_ONLY) rx_trig_q <= 1'b1;
      end
      if (capture) begin
        rx_hold_q <= sh_word_i;
        rx_full_q <= 1'b1;
      end
    end
  end

  assign cs_act      = force_cs_i | sh_busy_i;
  assign cs_o        = cs_act ^ cs_low_i;
  assign load_word_o = tx_hold_q;
  assign rx_data_o   = rx_hold_q;
  assign txs_o       = ~tx_full_q;
  assign rxs_o       = rx_full_q;
  assign eot_o       = ~sh_busy_i & ~pending;

  // R8
  txs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && en_i |=> !txs_o);
  // R9
  rxs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && !sh_done_i |=> !rxs_o);
  // R11
  dis_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !sh_busy_i |=> txs_o && !rxs_o);
  // R7
  rx_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && en_i && (mode == XFER_RX_ONLY) |=> !eot_o);
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 4,
  localparam int unsigned LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  wlen_m1_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cs_low_i,
  input  logic              force_cs_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              txs_o,
  output logic              rxs_o,
  output logic              eot_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_o,
  input  logic              miso_i
);
  logic              tick, busy, done, load;
  logic [DATA_W-1:0] load_word, sh_word;

  spi_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  spi_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .word_i    (load_word),
    .wlen_m1_i (wlen_m1_i),
    .cpol_i    (cpol_i),
    .cpha_i    (cpha_i),
    .tick_i    (tick),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .done_o    (done),
    .rx_word_o (sh_word),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o)
  );

  spi_chan_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .force_cs_i  (force_cs_i),
    .cs_low_i    (cs_low_i),
    .tx_wr_i     (tx_wr_i),
    .tx_data_i   (tx_data_i),
    .rx_rd_i     (rx_rd_i),
    .sh_busy_i   (busy),
    .sh_done_i   (done),
    .sh_word_i   (sh_word),
    .load_o      (load),
    .load_word_o (load_word),
    .rx_data_o   (rx_data_o),
    .txs_o       (txs_o),
    .rxs_o       (rxs_o),
    .eot_o       (eot_o),
    .cs_o        (cs_o)
  );
endmodule

// File: tb/test_spi_chan_engine.sv
`timescale 1ns/1ps
module test_spi_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  wlm1 = 5'd7;
  logic [3:0]  div = 4'd0;
  logic        cpol = 1'b0, cpha = 1'b0, cs_low = 1'b1, force_cs = 1'b0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0;
  logic [31:0] tx_data = '0;
  wire  [31:0] rx_data;
  wire         txs, rxs, eot, sclk, mosi, cs, miso;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_chan_engine i_spi_chan_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .wlen_m1_i(wlm1),
    .clk_div_i(div), .cpol_i(cpol), .cpha_i(cpha), .cs_low_i(cs_low),
    .force_cs_i(force_cs), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .txs_o(txs), .rxs_o(rxs), .eot_o(eot), .sclk_o(sclk),
    .mosi_o(mosi), .cs_o(cs), .miso_i(miso)
  );

  function automatic logic [31:0] spat(input int i);
    return (32'h6D2B_79F5 * 32'(i + 3)) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] mpat(input int k);
    return (32'hC3A5_96E1 * 32'(k + 7)) + 32'(k);
  endfunction
  function automatic logic [31:0] wmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // bus-side slave model
  bit          sl_on = 1'b0;
  int          nb = 8;
  logic [31:0] sl_tx = '0, sl_rx = '0, sl_last = '0;
  int          sl_pos = 0, sl_words = 0, sl_edges = 0;
  logic        miso_r = 1'b0;
  longint      t_first = 0, span = 0;
  logic        lead;

  assign miso = cpha ? miso_r : sl_tx[(sl_pos < nb) ? (nb - 1 - sl_pos) : 0];

  task automatic sl_reset();
    sl_pos = 0; sl_words = 0; sl_edges = 0; sl_rx = '0; sl_tx = spat(0); miso_r = 1'b0;
  endtask

  task automatic sl_word_end();
    sl_last  = sl_rx & wmask(nb);
    span     = $time - t_first;
    sl_words = sl_words + 1;
    sl_edges = 0;
    sl_pos   = 0;
    sl_rx    = '0;
    sl_tx    = spat(sl_words);
  endtask

  always @(sclk) begin
    if (sl_on && rst_n) begin
      lead = (sclk != cpol);
      if (sl_edges == 0) t_first = $time;
      sl_edges = sl_edges + 1;
      if (!cpha) begin
        if (lead) sl_rx = {sl_rx[30:0], mosi};
        else begin
          sl_pos = sl_pos + 1;
          if (sl_pos == nb) sl_word_end();
        end
      end else begin
        if (lead) begin
          miso_r = sl_tx[nb - 1 - sl_pos];
          sl_pos = sl_pos + 1;
        end else begin
          sl_rx = {sl_rx[30:0], mosi};
          if (sl_pos == nb) sl_word_end();
        end
      end
    end
  end

  bit mon_cs = 1'b0;
  int cs_bad = 0;
  always @(negedge clk) if (mon_cs && cs !== 1'b0) cs_bad++;

  task automatic cfg(input bit cp, input bit ph, input int wl, input int d, input logic [1:0] md);
    sl_on = 1'b0;
    @(negedge clk);
    cpol = cp; cpha = ph; wlm1 = 5'(wl - 1); div = 4'(d); mode = md; en = 1'b1;
    repeat (3) @(negedge clk);
    nb = wl;
    sl_reset();
    sl_on = 1'b1;
  endtask

  task automatic write_tx(input logic [31:0] w);
    tx_data = w; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  int wls[4] = '{4, 8, 13, 32};

  initial begin : main
    logic [31:0] w0, w1, m, prev_rx;
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(txs == 1'b1, "R12 txs", 64'(txs), 1);
    chk(rxs == 1'b0, "R12 rxs", 64'(rxs), 0);
    chk(eot == 1'b1, "R12 eot", 64'(eot), 1);
    chk(rx_data == 32'd0, "R12 rx_data", 64'(rx_data), 0);
    chk(cs == 1'b1, "R12 cs inactive", 64'(cs), 1);
    chk(sclk == cpol, "R12 sclk idle", 64'(sclk), 64'(cpol));

    // sweep: R1 R2 R3 R8 R9 R10 R5
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int wi = 0; wi < 4; wi++)
          for (int d = 0; d < 3; d++) begin
            cfg(cp[0], ph[0], wls[wi], d, 2'b00);
            m  = wmask(nb);
            w0 = mpat(k); w1 = mpat(k + 1); k += 2;
            write_tx(w0);
            chk(txs == 1'b0, "R8 txs cleared by write", 64'(txs), 0);
            chk(eot == 1'b0, "R10 eot low while pending", 64'(eot), 0);
            while (!txs) @(negedge clk);
            write_tx(w1);
            while (!rxs) @(negedge clk);
            chk(rx_data == (spat(0) & m), "R3 R1 rx word0", 64'(rx_data), 64'(spat(0) & m));
            chk(sl_last == (w0 & m), "R1 mosi msb-first word0", 64'(sl_last), 64'(w0 & m));
            read_rx();
            chk(rxs == 1'b0, "R9 rxs cleared by read", 64'(rxs), 0);
            while (!rxs) @(negedge clk);
            chk(rx_data == (spat(1) & m), "R3 R1 rx word1", 64'(rx_data), 64'(spat(1) & m));
            chk(sl_last == (w1 & m), "R1 mosi word1", 64'(sl_last), 64'(w1 & m));
            read_rx();
            while (!eot) @(negedge clk);
            chk(cs == cs_low, "R5 cs released after word", 64'(cs), 64'(cs_low));
            chk(sclk == cpol, "R2 sclk idle level", 64'(sclk), 64'(cpol));
            chk(span == longint'((2 * nb - 1) * (1 << d) * 8), "R2 edge span",
                64'(span), 64'((2 * nb - 1) * (1 << d) * 8));
          end

    // R2 larger divider
    cfg(1'b0, 1'b1, 4, 5, 2'b11);
    write_tx(32'h9);
    while (!rxs) @(negedge clk);
    chk(span == longint'(7 * 32 * 8), "R2 divider D=5", 64'(span), 64'(7 * 32 * 8));
    chk(rx_data == (spat(0) & 32'hF), "R6 reserved mode acts duplex", 64'(rx_data), 64'(spat(0) & 32'hF));
    read_rx();
    while (!eot) @(negedge clk);

    // R6 transmit-only
    cfg(1'b1, 1'b0, 12, 1, 2'b10);
    prev_rx = rx_data;
    write_tx(32'hABC5_6F1D);
    while (!eot) @(negedge clk);
    chk(sl_words == 1, "R6 tx-only word sent", 64'(sl_words), 1);
    chk(sl_last == (32'hABC5_6F1D & wmask(12)), "R6 tx-only data", 64'(sl_last), 64'(32'hABC5_6F1D & wmask(12)));
    chk(rxs == 1'b0, "R6 tx-only no rxs", 64'(rxs), 0);
    chk(rx_data == prev_rx, "R6 tx-only rx unchanged", 64'(rx_data), 64'(prev_rx));

    // R7 receive-only
    cfg(1'b0, 1'b1, 16, 1, 2'b01);
    repeat (20) @(negedge clk);
    chk(eot == 1'b1 && sl_words == 0, "R7 no start without dummy", 64'(sl_words), 0);
    write_tx(32'h0000_5A3C);
    for (int i = 0; i < 3; i++) begin
      while (!rxs) @(negedge clk);
      chk(rx_data == (spat(i) & wmask(16)), "R7 rx-only word", 64'(rx_data), 64'(spat(i) & wmask(16)));
      if (i == 2) mode = 2'b00;
      read_rx();
    end
    repeat (100) @(negedge clk);
    chk(sl_words == 3, "R7 stream stops after mode switch", 64'(sl_words), 3);
    chk(eot == 1'b1, "R10 eot after stream", 64'(eot), 1);
    chk(sl_last == 32'h0000_5A3C, "R7 dummy shifted", 64'(sl_last), 64'h5A3C);

    // R11 disable
    cfg(1'b0, 1'b0, 8, 2, 2'b00);
    en = 1'b0;
    write_tx(32'h77);
    repeat (10) @(negedge clk);
    chk(txs == 1'b1 && eot == 1'b1, "R11 write ignored while disabled", 64'({txs, eot}), 3);
    chk(sl_edges == 0 && sl_words == 0, "R11 no shifting while disabled", 64'(sl_edges), 0);
    en = 1'b1;
    repeat (10) @(negedge clk);
    chk(eot == 1'b1 && sl_words == 0, "R11 discarded write stays discarded", 64'(sl_words), 0);
    write_tx(32'hC6);
    while (!txs) @(negedge clk);
    en = 1'b0;
    repeat (200) @(negedge clk);
    chk(sl_words == 1 && sl_last == 32'hC6, "R11 word completes after disable", 64'(sl_last), 64'hC6);
    chk(rxs == 1'b0 && txs == 1'b1, "R11 flags at reset values", 64'({txs, rxs}), 2);

    // R5 R4 forced chip-select
    cfg(1'b0, 1'b0, 8, 1, 2'b00);
    force_cs = 1'b1;
    @(negedge clk);
    mon_cs = 1'b1;
    for (int i = 0; i < 2; i++) begin
      write_tx(mpat(100 + i));
      while (!rxs) @(negedge clk);
      read_rx();
    end
    while (!eot) @(negedge clk);
    repeat (5) @(negedge clk);
    mon_cs = 1'b0;
    chk(cs_bad == 0, "R5 cs held across words", 64'(cs_bad), 0);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs == 1'b0, "R5 forced cs independent of enable", 64'(cs), 0);
    cs_low = 1'b0;
    @(negedge clk);
    chk(cs == 1'b1, "R4 active-high forced cs", 64'(cs), 1);
    force_cs = 1'b0;
    @(negedge clk);
    chk(cs == 1'b0, "R4 active-high idle cs", 64'(cs), 0);

    finish_run();
  end
endmodule